// File: doc/BRIEF.md
# Shared Four-Port Integer Calculator

This block gives four independent requesters access to two shared 32-bit execution units. One unit adds and subtracts unsigned values. The other shifts logically in either direction. A requester places a command code with two operands on its port for a single cycle. The block holds the request in a per-port slot until the unit it needs grants it. The unit then computes the result, and the block drives a one-cycle response (a status code and a data word) on the port that sent the request.

Each unit has its own round-robin arbiter, so an arithmetic request and a shift request from different ports can proceed in the same cycle. Command codes outside the defined set never reach a unit. They are answered with an error response after the same latency as a valid command. A carry out of an addition is an error. So is a subtraction whose second operand is larger than its first. Each port may have only one request outstanding at a time.

Top module: `calc_hub`

## Requirements
- R1: While reset is applied, and after reset until a request has been answered, every port shows response code 2'b00 with data 0.
- R2: Command 0x1 (add) returns code 2'b01 with the 32-bit sum when the unsigned sum fits in 32 bits. When the sum carries out of bit 31 it returns code 2'b10.
- R3: Command 0x2 (subtract) returns code 2'b01 with first minus second when the second operand is not greater than the first, so two equal operands give 0. Otherwise it returns code 2'b10.
- R4: Commands 0x5 (shift left) and 0x6 (shift right) are logical shifts of the first operand and fill the vacated bits with zeros. The shift amount comes only from bits [4:0] of the second operand. An amount of 0 returns the first operand unchanged with code 2'b01.
- R5: Every code other than 0x0, 0x1, 0x2, 0x5 and 0x6 (this includes 0x3, 0x4, 0x7, 0x8 and 0x9 through 0xF) returns code 2'b10.
- R6: A response with code 2'b10 always carries data 0, and code 2'b11 never appears.
- R7: When a request meets no competition for its unit, a request sampled at rising edge k produces its response during the cycle after edge k+2. The response lasts exactly one cycle.
- R8: Each unit grants one waiting port per cycle in round-robin order. When all four ports request the same unit in one cycle, they are answered in four consecutive cycles, with latencies 3, 4, 5 and 6 cycles counted as in R7.
- R9: A response appears only on the port that issued the request, and only once per request.
- R10: A port may issue its next request in the cycle in which its previous response is visible. Requests to different units from different ports in the same cycle do not delay each other.
- R11: Command 0x0 is not a request. Its operands are ignored, and no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_cmd | input | 4x4 | Command code for each port. 0x0 means no request |
| req_opa | input | 4x32 | First operand for each port |
| req_opb | input | 4x32 | Second operand for each port |
| rsp_code | output | 4x2 | Response status for each port: 00 idle, 01 success, 10 error |
| rsp_data | output | 4x32 | Response data for each port. It is 0 on an error |

## Verification
A corrupted round-robin pointer or a wrong stage port tag shows at the ports within a few cycles. The symptom is either a response on a port that has nothing outstanding, or a request whose answer arrives outside the three-to-six cycle window. A stale or mis-cleared pending slot shows as a duplicate response, or as a request that is never answered. The outstanding-request timeout catches the second case no later than seven cycles after the request was issued. Wrong data paths, such as carry or borrow taken from the wrong side, shift amounts using high bits, or illegal codes sent into a unit, appear in the very first response that exercises them.

// File: rtl/calc_pkg.sv
package calc_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] OP_NOP = 4'h0;
  localparam logic [CMD_W-1:0] OP_ADD = 4'h1;
  localparam logic [CMD_W-1:0] OP_SUB = 4'h2;
  localparam logic [CMD_W-1:0] OP_SHL = 4'h5;
  localparam logic [CMD_W-1:0] OP_SHR = 4'h6;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_ERR  = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    DST_NONE  = 2'd0,
    DST_ARITH = 2'd1,
    DST_SHIFT = 2'd2,
    DST_BAD   = 2'd3
  } dst_e;

  // Destination of a command code
  function automatic dst_e route_of(input logic [CMD_W-1:0] code);
    case (code)
      OP_NOP:         route_of = DST_NONE;
      OP_ADD, OP_SUB: route_of = DST_ARITH;
      OP_SHL, OP_SHR: route_of = DST_SHIFT;
      default:        route_of = DST_BAD;
    endcase
  endfunction

endpackage

// File: rtl/calc_rr_arb.sv
module calc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          arb_hit;

  // Search starts at the pointer, first waiting port wins
  always_comb begin
    gnt     = '0;
    ptr_d   = ptr_q;
    arb_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(ptr_q) + i) % N;
      if (!arb_hit && req[idx]) begin
        gnt[idx] = 1'b1;
        arb_hit  = 1'b1;
        ptr_d    = PW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (arb_hit) begin
      ptr_q <= ptr_d;
    end
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R8
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/calc_exec_unit.sv
module calc_exec_unit
  import calc_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int DW      = 32,
  parameter bit SHIFTER = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            gnt,
  input  logic [NPORT-1:0][CMD_W-1:0] cmd,
  input  logic [NPORT-1:0][DW-1:0]    opa,
  input  logic [NPORT-1:0][DW-1:0]    opb,
  output logic [NPORT-1:0]            res_port,
  output logic                        res_ok,
  output logic [DW-1:0]               res_data
);

  // Second command of the pair selects the alternate operation
  localparam logic [CMD_W-1:0] ALT_CODE = SHIFTER ? OP_SHR : OP_SUB;

  logic [DW-1:0]    pick_a;
  logic [DW-1:0]    pick_b;
  logic             pick_alt;
  logic             load_en;

  logic [NPORT-1:0] st_port_q;
  logic [DW-1:0]    st_a_q;
  logic [DW-1:0]    st_b_q;
  logic             st_alt_q;

  // Operand select from the one-hot grant
  always_comb begin
    pick_a   = '0;
    pick_b   = '0;
    pick_alt = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      pick_a   = pick_a | (opa[p] & {DW{gnt[p]}});
      pick_b   = pick_b | (opb[p] & {DW{gnt[p]}});
      pick_alt = pick_alt | (gnt[p] && (cmd[p] == ALT_CODE));
    end
    load_en = |gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_port_q <= '0;
    end else begin
      st_port_q <= gnt;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      st_a_q   <= pick_a;
      st_b_q   <= pick_b;
      st_alt_q <= pick_alt;
    end
  end

  assign res_port = st_port_q;

  generate
    if (SHIFTER) begin : g_shift
      localparam int SHW = $clog2(DW);
      logic [SHW-1:0] shamt;
      logic           unused_hi;
      assign shamt     = st_b_q[SHW-1:0];
      assign unused_hi = ^st_b_q[DW-1:SHW];
      always_comb begin
        res_ok   = 1'b1;
        res_data = st_alt_q ? (st_a_q >> shamt) : (st_a_q << shamt);
      end
    end else begin : g_arith
      logic [DW:0]   sum_w;
      logic [DW-1:0] diff_w;
      logic          borrow_w;
      always_comb begin
        sum_w    = {1'b0, st_a_q} + {1'b0, st_b_q};
        diff_w   = st_a_q - st_b_q;
        borrow_w = st_b_q > st_a_q;
        res_ok   = st_alt_q ? !borrow_w : !sum_w[DW];
        if (!res_ok)       res_data = '0;
        else if (st_alt_q) res_data = diff_w;
        else               res_data = sum_w[DW-1:0];
      end
    end
  endgenerate

  // R7
  grant_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (res_port == $past(gnt)));

  // R9
  stage_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_port));

endmodule

// File: rtl/calc_hub.sv
module calc_hub
  import calc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0][CMD_W-1:0] req_cmd,
  input  logic [NPORT-1:0][DW-1:0]    req_opa,
  input  logic [NPORT-1:0][DW-1:0]    req_opb,
  output logic [NPORT-1:0][1:0]       rsp_code,
  output logic [NPORT-1:0][DW-1:0]    rsp_data
);

  // Reset synchronizer
  logic rst_q1;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_n_s <= rst_q1;
    end
  end

  // Per-port pending slots
  logic [NPORT-1:0]            pend_vld_q;
  logic [NPORT-1:0]            pend_vld_d;
  dst_e                        pend_dst_q [NPORT];
  dst_e                        dst_in     [NPORT];
  logic [NPORT-1:0][CMD_W-1:0] pend_cmd_q;
  logic [NPORT-1:0][DW-1:0]    pend_a_q;
  logic [NPORT-1:0][DW-1:0]    pend_b_q;
  logic [NPORT-1:0]            take_in;
  logic [NPORT-1:0]            leave;
  logic [NPORT-1:0]            bad_d;
  logic [NPORT-1:0]            bad_q;
  logic [NPORT-1:0]            ar_req;
  logic [NPORT-1:0]            sh_req;
  logic [NPORT-1:0]            ar_gnt;
  logic [NPORT-1:0]            sh_gnt;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      dst_in[p]     = route_of(req_cmd[p]);
      take_in[p]    = !pend_vld_q[p] && (dst_in[p] != DST_NONE);
      ar_req[p]     = pend_vld_q[p] && (pend_dst_q[p] == DST_ARITH);
      sh_req[p]     = pend_vld_q[p] && (pend_dst_q[p] == DST_SHIFT);
      bad_d[p]      = pend_vld_q[p] && (pend_dst_q[p] == DST_BAD);
      leave[p]      = ar_gnt[p] || sh_gnt[p] || bad_d[p];
      pend_vld_d[p] = take_in[p] || (pend_vld_q[p] && !leave[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pend_vld_q <= '0;
      bad_q      <= '0;
    end else begin
      pend_vld_q <= pend_vld_d;
      bad_q      <= bad_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (take_in[p]) begin
        pend_dst_q[p] <= dst_in[p];
        pend_cmd_q[p] <= req_cmd[p];
        pend_a_q[p]   <= req_opa[p];
        pend_b_q[p]   <= req_opb[p];
      end
    end
  end

  // Arbiters and shared units
  logic [NPORT-1:0] ar_port;
  logic [NPORT-1:0] sh_port;
  logic             ar_ok;
  logic             sh_ok;
  logic [DW-1:0]    ar_data;
  logic [DW-1:0]    sh_data;

  calc_rr_arb #(.N(NPORT)) u_arb_arith (
    .clk(clk), .rst_n(rst_n_s), .req(ar_req), .gnt(ar_gnt)
  );

  calc_rr_arb #(.N(NPORT)) u_arb_shift (
    .clk(clk), .rst_n(rst_n_s), .req(sh_req), .gnt(sh_gnt)
  );

  calc_exec_unit #(.NPORT(NPORT), .DW(DW), .SHIFTER(1'b0)) u_arith (
    .clk(clk), .rst_n(rst_n_s), .gnt(ar_gnt), .cmd(pend_cmd_q),
    .opa(pend_a_q), .opb(pend_b_q),
    .res_port(ar_port), .res_ok(ar_ok), .res_data(ar_data)
  );

  calc_exec_unit #(.NPORT(NPORT), .DW(DW), .SHIFTER(1'b1)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .gnt(sh_gnt), .cmd(pend_cmd_q),
    .opa(pend_a_q), .opb(pend_b_q),
    .res_port(sh_port), .res_ok(sh_ok), .res_data(sh_data)
  );

  // Response routing and registers
  rsp_e          rsp_q [NPORT];
  rsp_e          rsp_d [NPORT];
  logic [DW-1:0] dat_q [NPORT];
  logic [DW-1:0] dat_d [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      if (ar_port[p]) begin
        rsp_d[p] = ar_ok ? RSP_OK : RSP_ERR;
        dat_d[p] = ar_ok ? ar_data : '0;
      end else if (sh_port[p]) begin
        rsp_d[p] = sh_ok ? RSP_OK : RSP_ERR;
        dat_d[p] = sh_ok ? sh_data : '0;
      end else if (bad_q[p]) begin
        rsp_d[p] = RSP_ERR;
        dat_d[p] = '0;
      end else begin
        rsp_d[p] = RSP_IDLE;
        dat_d[p] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int p = 0; p < NPORT; p++) begin
        rsp_q[p] <= RSP_IDLE;
        dat_q[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        rsp_q[p] <= rsp_d[p];
        dat_q[p] <= dat_d[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rsp_code[p] = rsp_q[p];
      rsp_data[p] = dat_q[p];
    end
  end

  generate
    for (genvar gp = 0; gp < NPORT; gp++) begin : g_chk
      // R6
      err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        (rsp_code[gp] == RSP_ERR) |-> (rsp_data[gp] == '0));

      // R6
      code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        rsp_code[gp] != 2'b11);

      // R7
      pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        (rsp_code[gp] != RSP_IDLE) |=> (rsp_code[gp] == RSP_IDLE));

      // R5
      bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        bad_q[gp] |=> (rsp_code[gp] == RSP_ERR));
    end
  endgenerate

endmodule

// File: tb/calc_hub_bench.sv
`timescale 1ns/1ps
module calc_hub_bench;

  localparam int NP = 4;

  logic                 clk;
  logic                 rst_n;
  logic [NP-1:0][3:0]   req_cmd;
  logic [NP-1:0][31:0]  req_opa;
  logic [NP-1:0][31:0]  req_opb;
  logic [NP-1:0][1:0]   rsp_code;
  logic [NP-1:0][31:0]  rsp_data;

  calc_hub u_calc_hub (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_opa(req_opa),
    .req_opb(req_opb), .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  bit          done = 0;
  bit          exact_mode;
  bit          busy [NP];
  int          t_iss [NP];
  int          last_lat [NP];
  logic [1:0]  e_code [NP];
  logic [31:0] e_data [NP];
  string       e_tag [NP];

  function automatic logic [33:0] ref_rsp(input logic [3:0] c,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
    logic [32:0] s;
    case (c)
      4'h1: begin
        s = {1'b0, a} + {1'b0, b};
        ref_rsp = s[32] ? {2'b10, 32'h0} : {2'b01, s[31:0]};
      end
      4'h2: ref_rsp = (b > a) ? {2'b10, 32'h0} : {2'b01, a - b};
      4'h5: ref_rsp = {2'b01, a << b[4:0]};
      4'h6: ref_rsp = {2'b01, a >> b[4:0]};
      default: ref_rsp = {2'b10, 32'h0};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_ports();
    for (int p = 0; p < NP; p++) begin
      if (rsp_code[p] != 2'b00) begin
        if (!busy[p]) begin
          chk(1'b0, "R9", $sformatf("unsolicited response port %0d", p), 64'(rsp_code[p]), 64'h0);
        end else begin
          int lat;
          chk(rsp_code[p] == e_code[p], e_tag[p], $sformatf("code port %0d", p),
              64'(rsp_code[p]), 64'(e_code[p]));
          chk(rsp_data[p] == e_data[p], e_tag[p], $sformatf("data port %0d", p),
              64'(rsp_data[p]), 64'(e_data[p]));
          lat = cyc - t_iss[p];
          last_lat[p] = lat;
          if (exact_mode) chk(lat == 3, "R7", "latency", 64'(lat), 64'd3);
          else            chk(lat >= 3 && lat <= 6, "R8", "latency window", 64'(lat), 64'd6);
          busy[p] = 1'b0;
        end
      end else if (busy[p] && (cyc - t_iss[p] > 6)) begin
        chk(1'b0, "R8", $sformatf("no response port %0d", p), 64'(cyc - t_iss[p]), 64'd6);
        busy[p] = 1'b0;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check_ports();
    for (int p = 0; p < NP; p++) begin
      req_cmd[p] = 4'h0;
      req_opa[p] = $urandom;
      req_opb[p] = $urandom;
    end
  endtask

  task automatic issue(input int p, input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    logic [33:0] r;
    r = ref_rsp(c, a, b);
    req_cmd[p] = c;
    req_opa[p] = a;
    req_opb[p] = b;
    e_code[p]  = r[33:32];
    e_data[p]  = r[31:0];
    e_tag[p]   = tag;
    busy[p]    = 1'b1;
    t_iss[p]   = cyc;
  endtask

  function automatic bit any_busy();
    any_busy = 1'b0;
    for (int p = 0; p < NP; p++) any_busy |= busy[p];
  endfunction

  task automatic wait_idle();
    do tick(); while (any_busy());
  endtask

  task automatic run1(input int p, input logic [3:0] c, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    issue(p, c, a, b, tag);
    wait_idle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    exact_mode = 1'b1;
    for (int p = 0; p < NP; p++) begin
      busy[p] = 1'b0; req_cmd[p] = 4'h0; req_opa[p] = '0; req_opb[p] = '0;
      last_lat[p] = 0; t_iss[p] = 0;
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(rsp_code[p] == 2'b00, "R1", "code in reset", 64'(rsp_code[p]), 64'h0);
      chk(rsp_data[p] == 32'h0, "R1", "data in reset", 64'(rsp_data[p]), 64'h0);
    end
    rst_n = 1'b1;
    repeat (4) tick();
    for (int p = 0; p < NP; p++) begin
      chk(rsp_code[p] == 2'b00, "R1", "code after reset", 64'(rsp_code[p]), 64'h0);
    end

    // R11: command 0 with operands yields nothing
    for (int i = 0; i < 6; i++) begin
      tick();
      for (int p = 0; p < NP; p++)
        chk(rsp_code[p] == 2'b00, "R11", "no-op answered", 64'(rsp_code[p]), 64'h0);
    end

    // R2 add, including the fourth port
    run1(0, 4'h1, 32'h0000_0001, 32'h0000_0002, "R2");
    run1(1, 4'h1, 32'hFFFF_FFFF, 32'h0000_0001, "R2");
    run1(2, 4'h1, 32'h8000_2345, 32'h8001_0000, "R2");
    run1(3, 4'h1, 32'h8000_2345, 32'h0001_0000, "R2");
    // R3 subtract
    run1(0, 4'h2, 32'h1111_1111, 32'h2000_0000, "R3");
    run1(1, 4'h2, 32'h1234_5678, 32'h1234_5678, "R3");
    run1(2, 4'h2, 32'hFFFF_FFFF, 32'h1111_1111, "R3");
    run1(3, 4'h2, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    // R4 shifts
    run1(0, 4'h6, 32'h8000_0000, 32'h0000_000F, "R4");
    run1(1, 4'h5, 32'h0000_00FF, 32'h0000_0008, "R4");
    run1(2, 4'h5, 32'h0000_00FF, 32'h0000_0000, "R4");
    run1(3, 4'h6, 32'hFF00_0000, 32'hFFFF_FFE4, "R4");
    run1(0, 4'h5, 32'hFFFF_FFFF, 32'h0000_001F, "R4");
    run1(1, 4'h6, 32'h1234_5678, 32'h0000_0020, "R4");
    // R5 / R6 illegal codes
    for (int c = 3; c < 16; c++) begin
      if (c != 5 && c != 6) run1(c % NP, 4'(c), $urandom, $urandom, "R5");
    end

    // R8 all four ports on the arithmetic unit in one cycle
    exact_mode = 1'b0;
    for (int rep = 0; rep < 2; rep++) begin
      int sum_l;
      int prod_l;
      for (int p = 0; p < NP; p++) issue(p, 4'h1, $urandom >> 1, $urandom >> 1, "R8");
      wait_idle();
      sum_l = 0;
      prod_l = 1;
      for (int p = 0; p < NP; p++) begin
        sum_l += last_lat[p];
        prod_l *= last_lat[p];
      end
      chk(sum_l == 18 && prod_l == 360, "R8", "latency set 3..6", 64'(prod_l), 64'd360);
    end

    // R10 arithmetic and shift pairs in one cycle
    issue(0, 4'h1, 32'd10, 32'd5, "R10");
    issue(1, 4'h2, 32'd10, 32'd5, "R10");
    issue(2, 4'h5, 32'd3, 32'd2, "R10");
    issue(3, 4'h6, 32'd64, 32'd3, "R10");
    wait_idle();
    chk(last_lat[0] + last_lat[1] == 7, "R10", "arith pair latency", 64'(last_lat[0] + last_lat[1]), 64'd7);
    chk(last_lat[2] + last_lat[3] == 7, "R10", "shift pair latency", 64'(last_lat[2] + last_lat[3]), 64'd7);

    // Random traffic with immediate reissue (R10)
    for (int i = 0; i < 4000; i++) begin
      tick();
      for (int p = 0; p < NP; p++) begin
        if (!busy[p] && ($urandom % 2 == 0)) begin
          logic [3:0]  c;
          logic [31:0] a;
          logic [31:0] b;
          int          sel;
          sel = $urandom % 16;
          if (sel < 4)       c = 4'h1;
          else if (sel < 7)  c = 4'h2;
          else if (sel < 10) c = 4'h5;
          else if (sel < 13) c = 4'h6;
          else begin
            c = 4'($urandom);
            while (c == 4'h0 || c == 4'h1 || c == 4'h2 || c == 4'h5 || c == 4'h6)
              c = 4'($urandom);
          end
          a = $urandom;
          b = $urandom;
          case ($urandom % 4)
            0: b = a;
            1: a = a | 32'h8000_0000;
            2: begin a = a >> 16; b = b >> 16; end
            default: ;
          endcase
          issue(p, c, a, b, (c == 4'h1) ? "R2" : (c == 4'h2) ? "R3" :
                            (c == 4'h5 || c == 4'h6) ? "R4" : "R5");
        end
      end
    end
    wait_idle();
    repeat (4) tick();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule